// File: doc/BRIEF.md
# Branch-Commanded Up/Down State Counter

This block is a small binary counter built to act as the state register of a counter-based state machine. On every rising clock edge, a two-bit branch command selects what happens next. The counter can keep its value, step up by one, step down by one, or take a new state from a data input. External decode logic works out the command from the current state and the machine's inputs. The counter stores the state and reports when a count step is about to wrap.

Counting is the cheap, preferred branch. Loading is the fallback for transitions to a state that is not adjacent to the current one. A load can be done in one of two ways, chosen by a mode input:

- **Asynchronous load.** The stored bits are forced through their preset and clear paths. The new state appears without waiting for a clock edge.
- **Synchronous load.** The load value goes through a chain of flops that retimes it to the clock. The retimed value is taken through the next-state multiplexer on the next edge.

An active-low reset clears the state at once and beats every other action.

Top module: `brc_counter`

## Requirements
- R1: While `rst_n` is low, `state_q` is 0 immediately, with no clock edge needed, and the retiming chain is cleared.
- R2: Command 2'b00 (hold) leaves `state_q` unchanged across a clock edge.
- R3: Command 2'b01 (step up) sets `state_q` to its value plus one on the clock edge, and 15 becomes 0.
- R4: Command 2'b10 (step down) sets `state_q` to its value minus one on the clock edge, and 0 becomes 15.
- R5: With command 2'b11 and `async_mode` high, `state_q` equals `load_val` without waiting for a clock edge. It keeps following `load_val` for as long as that command is applied.
- R6: With command 2'b11 and `async_mode` low, `state_q` does not change before the edge. On the edge it takes the value `load_val` had two edges earlier, because of the two-stage retiming chain.
- R7: `term_cnt` is high exactly when the command is step up and `state_q` is 15, or the command is step down and `state_q` is 0.
- R8: `load_val` has no effect on `state_q` while the command is not 2'b11.
- R9: `async_mode` has no effect on `state_q` while the command is not 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counting and synchronous loads happen on its rising edge |
| rst_n | input | 1 | Active-low asynchronous clear of the state and the retiming chain |
| cmd | input | 2 | Branch command: 00 hold, 01 step up, 10 step down, 11 load |
| load_val | input | 4 | Next-state value used by the load command |
| async_mode | input | 1 | 1 selects asynchronous preset/clear loading, 0 selects retimed clocked loading |
| state_q | output | 4 | Current state |
| term_cnt | output | 1 | High when the present step command will wrap the state |

## Verification
The bench drives a step up from 15 and a step down from 0. A counter without wrap handling would saturate there or leave the width, and `term_cnt` would fail to rise.

A synchronous load is issued one cycle after `load_val` changes, so the stale value must be taken. A design that skipped the retiming chain would show the new value one load too early.

Asynchronous loads are checked between clock edges, including a change of `load_val` while the load is held. A design that waited for the clock, or latched only the first value, would show the old state there.

Reset is also dropped in the middle of a cycle, and loads and mode changes are applied under non-load commands. These catch a clocked reset and any leak of the data or mode inputs into counting.

// File: rtl/brc_pkg.sv
package brc_pkg;

  // Branch command values; the encoding is visible at the top-level port.
  typedef enum logic [1:0] {
    BR_HOLD = 2'b00,
    BR_UP   = 2'b01,
    BR_DOWN = 2'b10,
    BR_LOAD = 2'b11
  } br_cmd_e;

  // Load style selected by the mode input.
  typedef enum logic {
    LD_CLOCKED = 1'b0,
    LD_FORCED  = 1'b1
  } ld_style_e;

endpackage

// File: rtl/brc_sync.sv
// Multi-stage retiming chain for the synchronous load value.
module brc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[LAST];

endmodule

// File: rtl/brc_next.sv
// Next-state selection and wrap detection for the branch counter.
module brc_next
  import brc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  br_cmd_e          cmd,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] ld_data,
  output logic [WIDTH-1:0] nxt,
  output logic             at_top,
  output logic             at_bottom,
  output logic             wrap
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;

  function automatic logic [WIDTH-1:0] step_up(input logic [WIDTH-1:0] v);
    logic [WIDTH:0] wide;
    wide = {1'b0, v} + {{WIDTH{1'b0}}, 1'b1};
    return wide[WIDTH-1:0];
  endfunction

  function automatic logic [WIDTH-1:0] step_down(input logic [WIDTH-1:0] v);
    logic [WIDTH:0] wide;
    wide = {1'b0, v} - {{WIDTH{1'b0}}, 1'b1};
    return wide[WIDTH-1:0];
  endfunction

  assign at_top    = (cur == TOP);
  assign at_bottom = (cur == BOT);

  always_comb begin
    unique case (cmd)
      BR_HOLD: nxt = cur;
      BR_UP:   nxt = step_up(cur);
      BR_DOWN: nxt = step_down(cur);
      BR_LOAD: nxt = ld_data;
      default: nxt = cur;
    endcase
  end

  always_comb begin
    wrap = 1'b0;
    if (cmd == BR_UP   && at_top)    wrap = 1'b1;
    if (cmd == BR_DOWN && at_bottom) wrap = 1'b1;
  end

endmodule

// File: rtl/brc_bit.sv
// One state bit: clocked D input plus asynchronous preset and clear paths.
module brc_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  input  logic clear,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n or posedge preset or posedge clear) begin
    if (!rst_n)      q <= 1'b0;
    else if (clear)  q <= 1'b0;
    else if (preset) q <= 1'b1;
    else             q <= d;
  end

endmodule

// File: rtl/brc_counter.sv
// Branch-commanded loadable up/down counter used as state-machine memory.
module brc_counter
  import brc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [WIDTH-1:0] load_val,
  input  logic             async_mode,
  output logic [WIDTH-1:0] state_q,
  output logic             term_cnt
);

  br_cmd_e          cmd_e;
  ld_style_e        style;
  logic             load_cmd;
  logic             async_ld;
  logic             sync_ld;
  logic [WIDTH-1:0] sync_data;
  logic [WIDTH-1:0] next_state;
  logic             at_top;
  logic             at_bottom;
  logic             wrap_evt;
  logic [WIDTH-1:0] preset_vec;
  logic [WIDTH-1:0] clear_vec;

  assign cmd_e    = br_cmd_e'(cmd);
  assign style    = ld_style_e'(async_mode);
  assign load_cmd = (cmd_e == BR_LOAD);
  assign async_ld = load_cmd && (style == LD_FORCED);
  assign sync_ld  = load_cmd && (style == LD_CLOCKED);

  brc_sync #(
    .WIDTH  (WIDTH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (load_val),
    .dout  (sync_data)
  );

  brc_next #(
    .WIDTH (WIDTH)
  ) u_next (
    .cmd       (cmd_e),
    .cur       (state_q),
    .ld_data   (sync_data),
    .nxt       (next_state),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .wrap      (wrap_evt)
  );

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign preset_vec[b] = async_ld &  load_val[b];
      assign clear_vec[b]  = async_ld & ~load_val[b];

      brc_bit u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (preset_vec[b]),
        .clear  (clear_vec[b]),
        .d      (next_state[b]),
        .q      (state_q[b])
      );
    end
  endgenerate

  assign term_cnt = wrap_evt;

endmodule

// File: rtl/brc_chk.sv
// Property checker for brc_counter, attached with bind.
module brc_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd,
  input logic [WIDTH-1:0] load_val,
  input logic             async_mode,
  input logic [WIDTH-1:0] state_q,
  input logic             term_cnt,
  input logic             async_ld,
  input logic             sync_ld,
  input logic [WIDTH-1:0] sync_data
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (state_q == '0);
    end
  end

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd) == 2'b00 && !async_ld) |-> state_q == $past(state_q));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd) == 2'b01 && !async_ld)
      |-> state_q == WIDTH'($past(state_q) + 1'b1));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd) == 2'b10 && !async_ld)
      |-> state_q == WIDTH'($past(state_q) - 1'b1));

  // R5
  forced_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_ld |-> state_q == load_val);

  // R6
  clocked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sync_ld) && !async_ld) |-> state_q == $past(sync_data));

  // R7
  wrap_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |-> (cmd == 2'b01 || cmd == 2'b10));

  // R7
  wrap_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_cnt && cmd == 2'b01) |=> (state_q == '0 || async_ld));

endmodule

bind brc_counter brc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd        (cmd),
  .load_val   (load_val),
  .async_mode (async_mode),
  .state_q    (state_q),
  .term_cnt   (term_cnt),
  .async_ld   (async_ld),
  .sync_ld    (sync_ld),
  .sync_data  (sync_data)
);

// File: tb/brc_counter_tb.sv
module brc_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [3:0] load_val = 4'd0;
  logic       async_mode = 1'b0;
  logic [3:0] state_q;
  logic       term_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  brc_counter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .load_val   (load_val),
    .async_mode (async_mode),
    .state_q    (state_q),
    .term_cnt   (term_cnt)
  );

  // {cmd[2], load_val[4], async_mode[1], exp_term_cnt[1], exp_state_after_edge[4]}
  localparam int NV = 22;
  localparam logic [11:0] VEC [NV] = '{
    {2'b01, 4'd0,  1'b0, 1'b0, 4'd1 },  // R3
    {2'b01, 4'd0,  1'b0, 1'b0, 4'd2 },  // R3
    {2'b00, 4'd0,  1'b0, 1'b0, 4'd2 },  // R2
    {2'b10, 4'd0,  1'b0, 1'b0, 4'd1 },  // R4
    {2'b10, 4'd0,  1'b0, 1'b0, 4'd0 },  // R4
    {2'b10, 4'd0,  1'b0, 1'b1, 4'd15},  // R4 R7 wrap down
    {2'b01, 4'd0,  1'b0, 1'b1, 4'd0 },  // R3 R7 wrap up
    {2'b00, 4'd9,  1'b0, 1'b0, 4'd0 },  // R8
    {2'b00, 4'd9,  1'b0, 1'b0, 4'd0 },  // R8
    {2'b11, 4'd9,  1'b0, 1'b0, 4'd9 },  // R6
    {2'b01, 4'd9,  1'b1, 1'b0, 4'd10},  // R9
    {2'b11, 4'd5,  1'b0, 1'b0, 4'd9 },  // R6 stale value
    {2'b00, 4'd5,  1'b0, 1'b0, 4'd9 },  // R2
    {2'b10, 4'd5,  1'b0, 1'b0, 4'd8 },  // R4
    {2'b11, 4'd3,  1'b1, 1'b0, 4'd3 },  // R5
    {2'b01, 4'd3,  1'b0, 1'b0, 4'd4 },  // R3
    {2'b11, 4'd3,  1'b0, 1'b0, 4'd3 },  // R6
    {2'b01, 4'd15, 1'b1, 1'b0, 4'd4 },  // R9 R8
    {2'b11, 4'd15, 1'b1, 1'b0, 4'd15},  // R5
    {2'b01, 4'd15, 1'b0, 1'b1, 4'd0 },  // R7
    {2'b10, 4'd0,  1'b0, 1'b1, 4'd15},  // R7
    {2'b10, 4'd0,  1'b0, 1'b0, 4'd14}   // R4
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    #12;
    check("R1 reset state", state_q, 0);
    check("R7 reset flag", term_cnt, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmd        = VEC[i][11:10];
      load_val   = VEC[i][9:6];
      async_mode = VEC[i][5];
      #1;
      check($sformatf("R7 term_cnt vec %0d", i), term_cnt, VEC[i][4]);
      @(posedge clk);
      #1;
      check($sformatf("R2-6/R8/R9 state vec %0d", i), state_q, VEC[i][3:0]);
    end

    // R5: forced load with no clock edge, then follows load_val
    @(negedge clk);
    cmd = 2'b11; async_mode = 1'b1; load_val = 4'd6;
    #1;
    check("R5 forced load before edge", state_q, 6);
    load_val = 4'd12;
    #1;
    check("R5 forced load follows data", state_q, 12);
    @(posedge clk);
    #1;
    check("R5 forced load after edge", state_q, 12);

    // R6: clocked load has no effect before the edge
    @(negedge clk);
    cmd = 2'b01; async_mode = 1'b0;
    @(posedge clk);
    #1;
    check("R3 step after forced load", state_q, 13);
    @(negedge clk);
    cmd = 2'b11;
    #1;
    check("R6 no change before edge", state_q, 13);
    @(posedge clk);
    #1;
    check("R6 clocked load on edge", state_q, 12);

    // R1: reset asserted in mid-cycle
    @(negedge clk);
    cmd = 2'b01;
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R3 step before reset", state_q, 14);
    #2;
    rst_n = 1'b0;
    #1;
    check("R1 mid-cycle reset clears", state_q, 0);
    @(posedge clk);
    #1;
    check("R1 reset holds over edge", state_q, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cmd = 2'b11;
    load_val = 4'd7;
    @(posedge clk);
    #1;
    check("R1 chain cleared by reset", state_q, 0);

    finish_run();
  end

endmodule